// File: doc/BRIEF.md
# Stacked-Die Select and Master Arbitration

This block models the per-die control logic of a stack of identical memory dies that share one set of vertical lines. Every die carries a one-hot identity derived from its position in the stack. A per-die master-select input decides which die hosts the active controller. Only that die's local request port is forwarded onto the shared lines, carrying chip select, write enable, address and write data to all dies at once. Each die compares the shared chip-select bits against its own identity. Only the die that matches lets its local SRAM take part in the access.

Read data from the addressed die comes back on a shared return bus. A die that is not answering a read drives zeros there, so the return bus is the OR of all dies. An access is refused, and an error flag is raised, when more than one die claims master or when a request selects more than one die. The flag is combinational in the cycle of the offending request. A refused access writes nothing and returns no data.

Top module: `die_stack`

## Requirements
- R1: After reset, with all requests idle, `rd_valid` is 0, `rd_data` is 0 and `err` is 0.
- R2: Die i holds the identity with only bit i set. Chip select is active low, and a request with only bit i of its chip-select vector low reaches die i and no other die.
- R3: Any die can be made master by raising its bit of `master_sel`. The request present on that die's local port is then the one carried out.
- R4: A request on the local port of a die whose `master_sel` bit is low is ignored. It writes nothing and produces no read response.
- R5: For an accepted read, `rd_valid` is 1 with the addressed word on `rd_data` in exactly the cycle after the request, and for that one cycle only.
- R6: Whenever `rd_valid` is 0, `rd_data` is all zero.
- R7: A valid master request with more than one chip-select bit low raises `err` in the same cycle. It writes no die and produces no read response.
- R8: With more than one `master_sel` bit high, `err` is 1 and no write or read takes place.
- R9: A valid request with no chip-select bit low touches no die. It gives no read response and does not raise `err`.
- R10: A write followed in the very next cycle by a read of the same die and address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_sel | input | NDIES | Bit i makes die i the master |
| req_valid | input | NDIES | Local request valid, one bit per die |
| req_we | input | NDIES | Local request is a write (1) or a read (0), per die |
| req_cs_n | input | NDIES x NDIES | Local active-low chip-select vector, per die |
| req_addr | input | NDIES x AW | Local word address, per die |
| req_wdata | input | NDIES x DW | Local write data, per die |
| rd_valid | output | 1 | Return bus carries read data this cycle |
| rd_data | output | DW | Return bus (OR of all dies) |
| err | output | 1 | Multiple masters or multiple chip selects in this cycle |

## Verification
The bench builds a four-die stack with 16-bit words and 16 words per die. At that size every identity bit, every die as master, and each pairing of a conflicting master or chip select can be driven directly. Write data differs per die and address, so a mis-routed chip select or a leaking non-master request shows up as a wrong word on the return bus. Back-to-back write/read and read/read sequences exercise the one-cycle return path and the zero level the bus falls back to.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int unsigned MAX_DIES = 8;

  // One-hot identity of the die at stack position idx.
  function automatic logic [MAX_DIES-1:0] die_identity(input int unsigned idx);
    logic [MAX_DIES-1:0] r;
    r = '0;
    r[idx] = 1'b1;
    return r;
  endfunction

  // True when more than one bit is set.
  function automatic logic multi_hot(input logic [MAX_DIES-1:0] v);
    return (v & (v - 1'b1)) != '0;
  endfunction

endpackage

// File: rtl/die_sram.sv
module die_sram #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end

endmodule

// File: rtl/die_ctrl.sv
module die_ctrl #(
  parameter int unsigned NDIES = 4,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 16
) (
  input  logic             master_en,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [NDIES-1:0] req_cs_n,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             drv_valid,
  output logic             drv_we,
  output logic [NDIES-1:0] drv_cs,
  output logic [AW-1:0]    drv_addr,
  output logic [DW-1:0]    drv_wdata
);
  // Only a master drives the shared lines; others contribute zeros to the OR.
  logic fwd;
  assign fwd = master_en & req_valid;

  always_comb begin
    drv_valid = fwd;
    drv_we    = fwd & req_we;
    drv_cs    = fwd ? ~req_cs_n : '0;
    drv_addr  = fwd ? req_addr  : '0;
    drv_wdata = fwd ? req_wdata : '0;
  end

endmodule

// File: rtl/die_slice.sv
module die_slice #(
  parameter int unsigned IDX   = 0,
  parameter int unsigned NDIES = 4,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             bus_we,
  input  logic [NDIES-1:0] bus_cs,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic             wr_hit,
  output logic             ret_valid,
  output logic [DW-1:0]    ret_data
);
  localparam logic [stk_pkg::MAX_DIES-1:0] ID_FULL = stk_pkg::die_identity(IDX);
  localparam logic [NDIES-1:0] ID = ID_FULL[NDIES-1:0];

  logic          hit;
  logic          rd_hit;
  logic [DW-1:0] q;

  assign hit    = acc_valid && (bus_cs == ID);
  assign wr_hit = hit & bus_we;
  assign rd_hit = hit & ~bus_we;

  die_sram #(.AW(AW), .DW(DW)) u_sram (
    .clk   (clk),
    .wr_en (wr_hit),
    .rd_en (rd_hit),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ret_valid <= 1'b0;
    else        ret_valid <= rd_hit;
  end

  assign ret_data = ret_valid ? q : '0;

  // R6: an idle die leaves the return bus at zero
  a_r6_idle_die_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |-> (ret_data == '0));

endmodule

// File: rtl/die_stack.sv
module die_stack #(
  parameter int unsigned NDIES = 4,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NDIES-1:0]           master_sel,
  input  logic [NDIES-1:0]           req_valid,
  input  logic [NDIES-1:0]           req_we,
  input  logic [NDIES-1:0][NDIES-1:0] req_cs_n,
  input  logic [NDIES-1:0][AW-1:0]   req_addr,
  input  logic [NDIES-1:0][DW-1:0]   req_wdata,
  output logic                       rd_valid,
  output logic [DW-1:0]              rd_data,
  output logic                       err
);
  logic [NDIES-1:0]            drv_valid, drv_we;
  logic [NDIES-1:0][NDIES-1:0] drv_cs;
  logic [NDIES-1:0][AW-1:0]    drv_addr;
  logic [NDIES-1:0][DW-1:0]    drv_wdata;

  logic [NDIES-1:0]            die_wr, die_ret_v;
  logic [NDIES-1:0][DW-1:0]    die_ret_d;

  logic             bus_valid, bus_we;
  logic [NDIES-1:0] bus_cs;
  logic [AW-1:0]    bus_addr;
  logic [DW-1:0]    bus_wdata;
  logic             master_conflict, cs_conflict, acc_valid;

  for (genvar i = 0; i < NDIES; i++) begin : g_die
    die_ctrl #(.NDIES(NDIES), .AW(AW), .DW(DW)) u_ctrl (
      .master_en (master_sel[i]),
      .req_valid (req_valid[i]),
      .req_we    (req_we[i]),
      .req_cs_n  (req_cs_n[i]),
      .req_addr  (req_addr[i]),
      .req_wdata (req_wdata[i]),
      .drv_valid (drv_valid[i]),
      .drv_we    (drv_we[i]),
      .drv_cs    (drv_cs[i]),
      .drv_addr  (drv_addr[i]),
      .drv_wdata (drv_wdata[i])
    );

    die_slice #(.IDX(i), .NDIES(NDIES), .AW(AW), .DW(DW)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .bus_we    (bus_we),
      .bus_cs    (bus_cs),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .wr_hit    (die_wr[i]),
      .ret_valid (die_ret_v[i]),
      .ret_data  (die_ret_d[i])
    );
  end

  // Shared lines: wired-OR of every die's drivers.
  always_comb begin
    bus_valid = 1'b0;
    bus_we    = 1'b0;
    bus_cs    = '0;
    bus_addr  = '0;
    bus_wdata = '0;
    rd_valid  = 1'b0;
    rd_data   = '0;
    for (int i = 0; i < NDIES; i++) begin
      bus_valid = bus_valid | drv_valid[i];
      bus_we    = bus_we    | drv_we[i];
      bus_cs    = bus_cs    | drv_cs[i];
      bus_addr  = bus_addr  | drv_addr[i];
      bus_wdata = bus_wdata | drv_wdata[i];
      rd_valid  = rd_valid  | die_ret_v[i];
      rd_data   = rd_data   | die_ret_d[i];
    end
  end

  assign master_conflict = stk_pkg::multi_hot(stk_pkg::MAX_DIES'(master_sel));
  assign cs_conflict     = bus_valid & stk_pkg::multi_hot(stk_pkg::MAX_DIES'(bus_cs));
  assign err             = master_conflict | cs_conflict;
  assign acc_valid       = bus_valid & ~err;

  // R2: at most one die answers a read
  a_r2_single_responder: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(die_ret_v));

  // R5: an accepted single-die read returns data the next cycle
  a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !bus_we && $countones(bus_cs) == 1) |=> rd_valid);

  // R6: the OR'd return bus is zero when nothing is returned
  a_r6_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  // R7: a flagged cycle writes no die
  a_r7_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (die_wr == '0));

  // R8: several masters give no read response
  a_r8_multi_master_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(master_sel) > 1) |=> !rd_valid);

  // R9: an empty chip select touches no die
  a_r9_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cs == '0) |-> (die_wr == '0 && !err));

endmodule

// File: tb/die_stack_bench.sv
module die_stack_bench;
  localparam int unsigned N  = 4;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         master_sel;
  logic [N-1:0]         req_valid, req_we;
  logic [N-1:0][N-1:0]  req_cs_n;
  logic [N-1:0][AW-1:0] req_addr;
  logic [N-1:0][DW-1:0] req_wdata;
  logic                 rd_valid, err;
  logic [DW-1:0]        rd_data;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  always #2 clk = ~clk;

  die_stack #(.NDIES(N), .AW(AW), .DW(DW)) u_die_stack (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .req_valid(req_valid), .req_we(req_we), .req_cs_n(req_cs_n),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = '0;
    req_we    = '0;
    req_cs_n  = '1;
    req_addr  = '0;
    req_wdata = '0;
  endtask

  task automatic put(input int m, input bit we, input logic [N-1:0] cs_n,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid[m] = 1'b1;
    req_we[m]    = we;
    req_cs_n[m]  = cs_n;
    req_addr[m]  = a;
    req_wdata[m] = d;
  endtask

  function automatic logic [N-1:0] sel_n(input int d);
    logic [N-1:0] v;
    v = '1;
    v[d] = 1'b0;
    return v;
  endfunction

  function automatic logic [DW-1:0] pat(input int d, input int a, input int salt);
    return DW'(16'h1000 * (d + 1) + 16'h0011 * a + salt);
  endfunction

  // Write through master m; err must stay low.
  task automatic do_write(input int m, input int d, input int a, input logic [DW-1:0] v, input string req);
    idle();
    put(m, 1'b1, sel_n(d), AW'(a), v);
    #1 chk(err == 1'b0, req, err, 0);
    step();
    idle();
  endtask

  // Read through master m; data one cycle later, zero again after.
  task automatic do_read(input int m, input int d, input int a, input logic [DW-1:0] v, input string req);
    idle();
    put(m, 1'b0, sel_n(d), AW'(a), 0);
    step();
    chk(rd_valid == 1'b1, {req, " R5 valid"}, rd_valid, 1);
    chk(rd_data == v, req, rd_data, v);
    idle();
    step();
    chk(rd_valid == 1'b0, "R5 single cycle", rd_valid, 0);
    chk(rd_data == '0, "R6 zero return", rd_data, 0);
  endtask

  task automatic t_reset();
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(rd_data == '0, "R1 rd_data", rd_data, 0);
    chk(err == 1'b0, "R1 err", err, 0);
  endtask

  task automatic t_identity();
    for (int d = 0; d < N; d++) do_write(0, d, 3, pat(d, 3, 0), "R2 write");
    for (int d = N - 1; d >= 0; d--) do_read(0, d, 3, pat(d, 3, 0), "R2 readback");
  endtask

  task automatic t_master_switch();
    master_sel = 4'b0100;
    for (int m = 0; m < N; m++) begin
      master_sel = '0;
      master_sel[m] = 1'b1;
      do_write(m, (m + 1) % N, 5, pat(m, 5, 7), "R3 write");
      do_read(m, (m + 1) % N, 5, pat(m, 5, 7), "R3 read");
    end
    master_sel = 4'b0100;
    idle();
    put(2, 1'b1, sel_n(1), 5, 16'hBEEF);
    put(0, 1'b1, sel_n(1), 5, 16'hDEAD);
    #1 chk(err == 1'b0, "R4 err", err, 0);
    step();
    idle();
    do_read(2, 1, 5, 16'hBEEF, "R4 non-master write ignored");
    put(0, 1'b0, sel_n(1), 5, 0);
    step();
    chk(rd_valid == 1'b0, "R4 non-master read", rd_valid, 0);
    chk(rd_data == '0, "R4 non-master data", rd_data, 0);
    idle();
    master_sel = 4'b0001;
  endtask

  task automatic t_multi_cs();
    idle();
    put(0, 1'b1, 4'b1100, 3, 16'h5555);
    #1 chk(err == 1'b1, "R7 err", err, 1);
    step();
    idle();
    put(0, 1'b0, 4'b1010, 3, 0);
    #1 chk(err == 1'b1, "R7 err read", err, 1);
    step();
    chk(rd_valid == 1'b0, "R7 no response", rd_valid, 0);
    idle();
    do_read(0, 0, 3, pat(0, 3, 0), "R7 die0 unchanged");
    do_read(0, 1, 3, pat(1, 3, 0), "R7 die1 unchanged");
  endtask

  task automatic t_multi_master();
    master_sel = 4'b0011;
    idle();
    put(0, 1'b1, sel_n(2), 3, 16'h7777);
    #1 chk(err == 1'b1, "R8 err", err, 1);
    step();
    idle();
    put(0, 1'b0, sel_n(2), 3, 0);
    step();
    chk(rd_valid == 1'b0, "R8 no response", rd_valid, 0);
    idle();
    master_sel = 4'b0001;
    #1 chk(err == 1'b0, "R8 err clears", err, 0);
    do_read(0, 2, 3, pat(2, 3, 0), "R8 die2 unchanged");
  endtask

  task automatic t_no_cs();
    idle();
    put(0, 1'b1, 4'b1111, 3, 16'h9999);
    #1 chk(err == 1'b0, "R9 err write", err, 0);
    step();
    idle();
    put(0, 1'b0, 4'b1111, 3, 0);
    #1 chk(err == 1'b0, "R9 err read", err, 0);
    step();
    chk(rd_valid == 1'b0, "R9 no response", rd_valid, 0);
    idle();
    for (int d = 0; d < N; d++) do_read(0, d, 3, pat(d, 3, 0), "R9 unchanged");
  endtask

  task automatic t_back_to_back();
    idle();
    put(0, 1'b1, sel_n(3), 7, 16'hA5C3);
    step();
    idle();
    put(0, 1'b0, sel_n(3), 7, 0);
    step();
    chk(rd_valid == 1'b1, "R10 valid", rd_valid, 1);
    chk(rd_data == 16'hA5C3, "R10 new data", rd_data, 16'hA5C3);
    idle();
    put(0, 1'b0, sel_n(0), 3, 0);
    step();
    idle();
    put(0, 1'b0, sel_n(1), 3, 0);
    chk(rd_data == pat(0, 3, 0), "R5 pipelined first", rd_data, pat(0, 3, 0));
    step();
    idle();
    chk(rd_data == pat(1, 3, 0), "R5 pipelined second", rd_data, pat(1, 3, 0));
    step();
    chk(rd_valid == 1'b0, "R5 pipeline drains", rd_valid, 0);
  endtask

  initial begin
    master_sel = 4'b0001;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_master_switch();
    t_multi_cs();
    t_multi_master();
    t_no_cs();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule